// File: doc/BRIEF.md
# Rectangle Overlap Search Co-processor

This block sits on a host's register bus and speeds up one inner loop of a layout rule checker: finding which shape in a list overlaps a given shape. Each shape is held as its bounding rectangle, packed into two 32-bit words. The host first stores a reference rectangle. After that the block can be used in two ways.

In passive use, the host writes one candidate rectangle and reads a hit flag from the status register. In list use, the host gives a base address and a record count and sets the start bit. The block then fetches the records itself through a simple read-request port. It halts at the first record that overlaps the reference, or after the last record. It then reports whether a hit was found and the index where it stopped.

The comparison is a purely combinational group of comparators. A record is therefore judged in the same cycle its second word arrives, and no extra wait cycles are added per record.

Top module: `rect_hit_scanner`

## Requirements
- R1: A rectangle record is two words. Word 0 carries the x span and word 1 the y span. In each word, bits [15:0] are the low coordinate and bits [31:16] the high coordinate, all unsigned.
- R2: Two rectangles overlap when, on both axes, each span's low coordinate is less than or equal to the other span's high coordinate. Spans that share only an edge value count as overlapping.
- R3: Status bit 2 shows, combinationally, whether the candidate registers overlap the reference. It reads 0 until both reference words have been written since reset.
- R4: Writing 1 to bit 0 of the control register (word select 6) starts a list walk. The write is ignored while a walk is running or before both reference words are loaded. With a nonzero count, status bit 0 (busy) reads 1 from the cycle after the accepted write.
- R5: The walker reads word w of record i at address base + 8*i + 4*w. Word 0 is read before word 1. It holds `mem_req` high with `mem_addr` unchanged until a cycle in which `mem_rvalid` is high.
- R6: When record i overlaps the reference, the walk ends with status bit 1 (found) set to 1 and status bits [31:16] set to i. No further reads are issued.
- R7: When no record overlaps, the walk ends after reading exactly 2*count words, with found set to 0 and the stop index set to count.
- R8: A start with count 0 issues no reads, never raises busy, and leaves found at 0 and the stop index at 0.
- R9: Writes to the reference words, the base register or the count register are ignored while busy is set.
- R10: After reset every register reads 0, and `mem_req` is low. Word selects 0 to 5 read back the reference x, reference y, candidate x, candidate y, base and count. Word select 7 returns status.
- R11: Every accepted start clears found, so a previous hit does not carry into the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register word select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| mem_req | output | 1 | Walker read request |
| mem_addr | output | 32 | Walker byte address |
| mem_rvalid | input | 1 | Read data valid; completes the pending request |
| mem_rdata | input | 32 | Read data |

## Verification
Passive candidates are placed inside the reference, fully around it, just past each edge and exactly on each edge. The just-past and on-edge cases separate the inclusive rule from a strict one, and cases that differ only in the y word confirm the word order. List walks cover a hit at index 0, a hit deep in the list, no hit at all and a zero count. Each walk is run at several read latencies, so holding the request and the address order are checked under stalls. One walk is given register writes while it runs, to show that its operands stay frozen.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

    localparam int WORD_W  = 32;
    localparam int COORD_W = 16;
    localparam int SEL_W   = 3;

    // register word selects
    localparam logic [SEL_W-1:0] RG_REF_X  = 3'd0;
    localparam logic [SEL_W-1:0] RG_REF_Y  = 3'd1;
    localparam logic [SEL_W-1:0] RG_CAND_X = 3'd2;
    localparam logic [SEL_W-1:0] RG_CAND_Y = 3'd3;
    localparam logic [SEL_W-1:0] RG_BASE   = 3'd4;
    localparam logic [SEL_W-1:0] RG_COUNT  = 3'd5;
    localparam logic [SEL_W-1:0] RG_CTRL   = 3'd6;
    localparam logic [SEL_W-1:0] RG_STATUS = 3'd7;

    // one axis: high coordinate in the upper half of the word
    typedef struct packed {
        logic [COORD_W-1:0] hi;
        logic [COORD_W-1:0] lo;
    } span_t;

    // a record: {word 1, word 0}
    typedef struct packed {
        span_t y;
        span_t x;
    } rect_t;

    typedef enum logic [1:0] {
        WK_IDLE    = 2'd0,
        WK_FETCH_X = 2'd1,
        WK_FETCH_Y = 2'd2
    } walk_state_t;

    // inclusive interval intersection
    function automatic logic spans_meet(span_t a, span_t b);
        return (a.lo <= b.hi) && (b.lo <= a.hi);
    endfunction

    function automatic rect_t make_rect(logic [WORD_W-1:0] wx, logic [WORD_W-1:0] wy);
        rect_t r;
        r.x = span_t'(wx);
        r.y = span_t'(wy);
        return r;
    endfunction

endpackage

// File: rtl/rhs_overlap_core.sv
module rhs_overlap_core
    import rhs_pkg::*;
(
    input  rect_t ref_i,
    input  rect_t cand_i,
    output logic  hit_o
);
    localparam int N_AXES = 2;

    span_t ref_sp  [N_AXES];
    span_t cand_sp [N_AXES];
    logic [N_AXES-1:0] axis_ok;

    assign ref_sp[0]  = ref_i.x;
    assign ref_sp[1]  = ref_i.y;
    assign cand_sp[0] = cand_i.x;
    assign cand_sp[1] = cand_i.y;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        assign axis_ok[g] = spans_meet(ref_sp[g], cand_sp[g]);
    end

    assign hit_o = &axis_ok;
endmodule

// File: rtl/rhs_regfile.sv
module rhs_regfile
    import rhs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [SEL_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    input  logic               busy_i,
    input  logic               found_i,
    input  logic [CNT_W-1:0]   stop_idx_i,
    input  logic               cand_core_hit_i,
    output rect_t              ref_o,
    output rect_t              cand_o,
    output logic [ADDR_W-1:0]  base_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               cand_hit_o,
    output logic               start_o
);
    localparam int IDX_FIELD_W = WORD_W - COORD_W;

    logic [WORD_W-1:0] ref_x_q, ref_y_q, cand_x_q, cand_y_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic [1:0]        ref_seen_q;
    logic              ref_ok;

    assign ref_ok = &ref_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_x_q    <= '0;
            ref_y_q    <= '0;
            cand_x_q   <= '0;
            cand_y_q   <= '0;
            base_q     <= '0;
            count_q    <= '0;
            ref_seen_q <= '0;
        end else if (host_wr) begin
            case (host_addr)
                RG_REF_X: if (!busy_i) begin
                    ref_x_q       <= host_wdata;
                    ref_seen_q[0] <= 1'b1;
                end
                RG_REF_Y: if (!busy_i) begin
                    ref_y_q       <= host_wdata;
                    ref_seen_q[1] <= 1'b1;
                end
                RG_CAND_X: cand_x_q <= host_wdata;
                RG_CAND_Y: cand_y_q <= host_wdata;
                RG_BASE:   if (!busy_i) base_q  <= host_wdata[ADDR_W-1:0];
                RG_COUNT:  if (!busy_i) count_q <= host_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign start_o = host_wr && (host_addr == RG_CTRL) && host_wdata[0]
                     && ref_ok && !busy_i;

    assign ref_o      = make_rect(ref_x_q, ref_y_q);
    assign cand_o     = make_rect(cand_x_q, cand_y_q);
    assign base_o     = base_q;
    assign count_o    = count_q;
    assign cand_hit_o = cand_core_hit_i && ref_ok;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RG_REF_X:  host_rdata = ref_x_q;
            RG_REF_Y:  host_rdata = ref_y_q;
            RG_CAND_X: host_rdata = cand_x_q;
            RG_CAND_Y: host_rdata = cand_y_q;
            RG_BASE:   host_rdata = WORD_W'(base_q);
            RG_COUNT:  host_rdata = WORD_W'(count_q);
            RG_STATUS: host_rdata = {IDX_FIELD_W'(stop_idx_i),
                                     {(COORD_W-3){1'b0}},
                                     cand_hit_o, found_i, busy_i};
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rhs_list_walker.sv
module rhs_list_walker
    import rhs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [CNT_W-1:0]   count_i,
    input  rect_t              ref_i,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               busy_o,
    output logic               found_o,
    output logic [CNT_W-1:0]   stop_idx_o
);
    localparam int REC_SHIFT = 3;

    walk_state_t       state_q;
    logic [CNT_W-1:0]  idx_q;
    logic [WORD_W-1:0] x_word_q;
    logic              found_q;
    logic [CNT_W-1:0]  stop_q;
    logic              rec_hit;
    logic              last_rec;
    rect_t             cand_rect;

    assign cand_rect = make_rect(x_word_q, mem_rdata);
    assign last_rec  = (idx_q == count_i - CNT_W'(1));

    rhs_overlap_core u_core (
        .ref_i  (ref_i),
        .cand_i (cand_rect),
        .hit_o  (rec_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WK_IDLE;
            idx_q    <= '0;
            x_word_q <= '0;
            found_q  <= 1'b0;
            stop_q   <= '0;
        end else begin
            case (state_q)
                WK_IDLE: if (start_i) begin
                    found_q <= 1'b0;
                    stop_q  <= '0;
                    idx_q   <= '0;
                    if (count_i != '0) state_q <= WK_FETCH_X;
                end
                WK_FETCH_X: if (mem_rvalid) begin
                    x_word_q <= mem_rdata;
                    state_q  <= WK_FETCH_Y;
                end
                WK_FETCH_Y: if (mem_rvalid) begin
                    if (rec_hit) begin
                        found_q <= 1'b1;
                        stop_q  <= idx_q;
                        state_q <= WK_IDLE;
                    end else if (last_rec) begin
                        stop_q  <= count_i;
                        state_q <= WK_IDLE;
                    end else begin
                        idx_q   <= idx_q + CNT_W'(1);
                        state_q <= WK_FETCH_X;
                    end
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q != WK_IDLE);
    assign mem_addr   = base_i + ADDR_W'({idx_q, {REC_SHIFT{1'b0}}})
                        + ((state_q == WK_FETCH_Y) ? ADDR_W'(4) : '0);
    assign busy_o     = (state_q != WK_IDLE);
    assign found_o    = found_q;
    assign stop_idx_o = stop_q;
endmodule

// File: rtl/rect_hit_scanner.sv
module rect_hit_scanner
    import rhs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic [SEL_W-1:0]     host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata
);
    rect_t             ref_rect;
    rect_t             cand_rect;
    logic [ADDR_W-1:0] cfg_base;
    logic [CNT_W-1:0]  cfg_count;
    logic              start_pulse;
    logic              walk_busy;
    logic              walk_found;
    logic [CNT_W-1:0]  walk_stop;
    logic              cand_core_hit;
    logic              cand_hit;

    rhs_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk             (clk),
        .rst             (rst),
        .host_wr         (host_wr),
        .host_addr       (host_addr),
        .host_wdata      (host_wdata),
        .host_rdata      (host_rdata),
        .busy_i          (walk_busy),
        .found_i         (walk_found),
        .stop_idx_i      (walk_stop),
        .cand_core_hit_i (cand_core_hit),
        .ref_o           (ref_rect),
        .cand_o          (cand_rect),
        .base_o          (cfg_base),
        .count_o         (cfg_count),
        .cand_hit_o      (cand_hit),
        .start_o         (start_pulse)
    );

    rhs_overlap_core u_passive (
        .ref_i  (ref_rect),
        .cand_i (cand_rect),
        .hit_o  (cand_core_hit)
    );

    rhs_list_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_pulse),
        .base_i     (cfg_base),
        .count_i    (cfg_count),
        .ref_i      (ref_rect),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy_o     (walk_busy),
        .found_o    (walk_found),
        .stop_idx_o (walk_stop)
    );
endmodule

// File: rtl/rhs_checker.sv
module rhs_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              busy,
    input logic              found,
    input logic [CNT_W-1:0]  stop_idx,
    input logic [CNT_W-1:0]  count,
    input logic [63:0]       ref_bits
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_req_needs_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_hit_index_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && found) |-> (stop_idx < count));

    assert_miss_index_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !found) |-> (stop_idx == count));

    assert_frozen_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ref_bits) && $stable(count)));
endmodule

bind rect_hit_scanner rhs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .busy       (walk_busy),
    .found      (walk_found),
    .stop_idx   (walk_stop),
    .count      (cfg_count),
    .ref_bits   (ref_rect)
);

// File: tb/rect_hit_scanner_bench.sv
module rect_hit_scanner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [31:0] mem [0:127];
    int lat = 0;
    int wcnt = 0;
    int nreads = 0;
    int exp_base = 0;
    int exp_k = 0;
    logic [31:0] ref_x, ref_y;

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_hit_scanner u_rect_hit_scanner (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_overlap(logic [31:0] ax, logic [31:0] ay,
                                         logic [31:0] bx, logic [31:0] by);
        return (ax[15:0] <= bx[31:16]) && (bx[15:0] <= ax[31:16]) &&
               (ay[15:0] <= by[31:16]) && (by[15:0] <= ay[31:16]);
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // memory responder with its own address expectation
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                wcnt = lat;
            end else if (mem_req) begin
                if (wcnt == 0) begin
                    chk("R5 read address", mem_addr, 32'(exp_base + 4 * exp_k));
                    exp_k++;
                    nreads++;
                    mem_rdata = mem[mem_addr[8:2]];
                    mem_rvalid = 1'b1;
                end else begin
                    wcnt--;
                end
            end else begin
                wcnt = lat;
            end
        end
    end

    task automatic put_rec(input int widx, input int xl, input int xh, input int yl, input int yh);
        mem[widx]     = {16'(xh), 16'(xl)};
        mem[widx + 1] = {16'(yh), 16'(yl)};
    endtask

    task automatic wait_idle(output logic [31:0] s);
        for (int n = 0; n < 4000; n++) begin
            host_read(3'd7, s);
            if (!s[0]) break;
        end
    endtask

    task automatic run_walk(input int base, input int cnt, input int latency,
                            input bit disturb, input string tag);
        logic [31:0] s;
        int ef = 0;
        int ei = cnt;
        int er;
        for (int i = 0; i < cnt; i++) begin
            if (model_overlap(ref_x, ref_y, mem[(base >> 2) + 2 * i], mem[(base >> 2) + 2 * i + 1])) begin
                ef = 1; ei = i; break;
            end
        end
        er = ef ? 2 * (ei + 1) : 2 * cnt;
        lat = latency; wcnt = latency;
        exp_base = base; exp_k = 0; nreads = 0;
        host_write(3'd4, 32'(base));
        host_write(3'd5, 32'(cnt));
        host_write(3'd6, 32'd1);
        host_read(3'd7, s);
        chk({tag, " R4 busy after start"}, 32'(s[0]), (cnt > 0) ? 32'd1 : 32'd0);
        chk({tag, " R11 found cleared at start"}, 32'(s[1]), 32'd0);
        if (disturb) begin
            // R9: these must not reach the running walk
            host_write(3'd0, 32'h0000_0000);
            host_write(3'd1, 32'hFFFF_0000);
            host_write(3'd5, 32'd1);
            host_write(3'd4, 32'h0000_0100);
            host_write(3'd6, 32'd1);
        end
        wait_idle(s);
        chk({tag, " busy cleared"}, 32'(s[0]), 32'd0);
        chk({tag, " R6/R7 found"}, 32'(s[1]), 32'(ef));
        chk({tag, " R6/R7 stop index"}, 32'(s[31:16]), 32'(ei));
        chk({tag, " R7/R8 read count"}, 32'(nreads), 32'(er));
        if (disturb) begin
            host_read(3'd0, s); chk("R9 ref x kept", s, ref_x);
            host_read(3'd1, s); chk("R9 ref y kept", s, ref_y);
            host_read(3'd5, s); chk("R9 count kept", s, 32'(cnt));
            host_read(3'd4, s); chk("R9 base kept", s, 32'(base));
        end
    endtask

    task automatic passive(input int xl, input int xh, input int yl, input int yh, input string tag);
        logic [31:0] s;
        logic [31:0] cx = {16'(xh), 16'(xl)};
        logic [31:0] cy = {16'(yh), 16'(yl)};
        host_write(3'd2, cx);
        host_write(3'd3, cy);
        host_read(3'd7, s);
        chk(tag, 32'(s[2]), 32'(model_overlap(ref_x, ref_y, cx, cy)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 128; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        host_read(3'd7, s); chk("R10 status after reset", s, 32'd0);
        host_read(3'd0, s); chk("R10 ref x after reset", s, 32'd0);
        chk("R10 no request after reset", 32'(mem_req), 32'd0);

        // R3/R4: nothing works before reference is loaded
        host_write(3'd2, {16'd10, 16'd0});
        host_write(3'd3, {16'd10, 16'd0});
        host_read(3'd7, s); chk("R3 no hit before ref", 32'(s[2]), 32'd0);
        host_write(3'd5, 32'd2);
        host_write(3'd6, 32'd1);
        host_read(3'd7, s); chk("R4 start ignored before ref", 32'(s[0]), 32'd0);
        chk("R4 no request before ref", 32'(mem_req), 32'd0);

        // reference: x 100..200, y 50..80 (R1 layout)
        ref_x = {16'd200, 16'd100};
        ref_y = {16'd80, 16'd50};
        host_write(3'd0, ref_x);
        host_write(3'd1, ref_y);
        host_read(3'd0, s); chk("R10 ref x readback", s, ref_x);
        host_read(3'd1, s); chk("R10 ref y readback", s, ref_y);

        // passive comparisons (R1, R2, R3)
        passive(120, 130, 60, 70, "R3 inside");
        passive(0, 999, 0, 999, "R3 enclosing");
        passive(0, 99, 60, 70, "R2 left gap");
        passive(0, 100, 60, 70, "R2 left edge touch");
        passive(200, 300, 60, 70, "R2 right edge touch");
        passive(201, 300, 60, 70, "R2 right gap");
        passive(120, 130, 81, 90, "R2 above gap");
        passive(120, 130, 80, 90, "R2 top edge touch");
        passive(120, 130, 10, 49, "R1 y word below");
        passive(60, 70, 120, 130, "R1 swapped axes miss");

        // list memory: base 0x40 -> word 16
        put_rec(16, 0, 50, 0, 40);
        put_rec(18, 300, 400, 60, 70);
        put_rec(20, 120, 130, 90, 95);
        put_rec(22, 150, 160, 80, 85);
        put_rec(24, 110, 120, 55, 60);
        run_walk(32'h40, 5, 0, 0, "R6 hit at 3 lat0");
        run_walk(32'h40, 3, 2, 0, "R7 no hit lat2");
        run_walk(32'h58, 2, 1, 0, "R6 hit at 0 lat1");
        run_walk(32'h40, 0, 0, 0, "R8 zero count");
        run_walk(32'h40, 3, 3, 0, "R11 miss after hit");

        // long latency walk disturbed by register writes
        put_rec(40, 0, 10, 0, 10);
        put_rec(42, 0, 10, 0, 10);
        put_rec(44, 190, 250, 75, 99);
        run_walk(32'hA0, 3, 12, 1, "R9 frozen walk");
        run_walk(32'hA0, 2, 0, 0, "R7 two record miss");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule